// File: doc/BRIEF.md
# Edge-Timed Period and High-Pulse Meter

This block times one digital input against an externally supplied free-running tick count. Software or a controlling sequencer raises `start` for one clock and picks a mode. In period mode the block waits for a rising edge and stores the tick value seen at that edge. It then waits for the following rising edge and reports the number of ticks between the two. In high-pulse mode the second event is the falling edge that follows the first rising edge, so the report is how long the input stayed high.

The difference is formed modulo 2^CNT_W, so the answer is still right if the counter rolls over once between the two edges. A finished measurement is signalled by `done` high for exactly one clock. `result` changes only at the clock edge that raises `done`, and it keeps its value until the next measurement completes. The result path has no back-pressure: the consumer must take the value while `done` is high, or read it later from the held `result`. The input is assumed to be synchronous to `clk`.

Top module: `pw_period_meter`

## Requirements
- R1: After reset, `done` is 0, `result` is 0, and the block is idle.
- R2: With `mode`=0 (period) at start, the result equals count(second rising edge) minus count(first rising edge) modulo 2^16. A falling edge between the two rising edges does not complete the measurement.
- R3: With `mode`=1 (high pulse) at start, the result equals count(first falling edge after the captured rising edge) minus count(that rising edge) modulo 2^16.
- R4: When the counter wraps once between the two edges, the result is still the true tick distance.
- R5: `done` is high for exactly one clock, in the cycle that follows the clock edge at which the completing edge is sampled. `result` holds its value at all other times.
- R6: Edges on `sig_in` while the block is idle produce no `done` and leave `result` unchanged.
- R7: Only edges that occur after `start` count. An edge sampled in the same clock as `start` is not captured, and a level that is already high at start is not taken as a rising edge.
- R8: Asserting `start` during a measurement discards any captured first timestamp and waits for a new first rising edge.
- R9: The mode is latched when `start` is asserted. Changing `mode` later has no effect on the running measurement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-clock request to begin or restart a measurement |
| mode | input | 1 | 0 = period between rising edges, 1 = high pulse width |
| sig_in | input | 1 | Measured signal, synchronous to clk |
| count | input | CNT_W | Free-running tick count |
| done | output | 1 | One-clock strobe marking a new result |
| result | output | CNT_W | Tick distance between the two captured edges |

## Verification
The hardest cases to reach from the ports are edges that land exactly on the start cycle, and restarts that happen after a first timestamp is already held. A stale capture in either case changes the reported number by a known amount. The bench places the input transition on the same negative edge as `start`, and it re-asserts `start` between the first and second edge. It then checks that the reported distance uses only the later timestamps. Since `count` is an input, the bench sets it directly at each edge. This lets it sweep first timestamps near zero, mid-range and the top of the range against many gaps, so single-wrap cases come up in both modes.

// File: rtl/pw_period_meter_pkg.sv
package pw_period_meter_pkg;
  typedef enum logic [1:0] {
    ST_IDLE        = 2'd0,
    ST_WAIT_FIRST  = 2'd1,
    ST_WAIT_SECOND = 2'd2,
    ST_DONE        = 2'd3
  } meas_state_t;

  typedef enum logic {
    MEAS_PERIOD = 1'b0,
    MEAS_HIGH   = 1'b1
  } meas_mode_t;
endpackage

// File: rtl/pwm_edge_detect.sv
module pwm_edge_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_in,
  output logic rise,
  output logic fall
);
  logic prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sig_in;
  end

  assign rise = sig_in & ~prev_q;
  assign fall = ~sig_in & prev_q;
endmodule

// File: rtl/pwm_meas_fsm.sv
module pwm_meas_fsm
  import pw_period_meter_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic mode_in,
  input  logic rise,
  input  logic fall,
  output logic cap_first,
  output logic cap_second,
  output logic done
);
  meas_state_t state_q, state_nxt;
  meas_mode_t  mode_q;
  logic        second_evt;

  assign second_evt = (mode_q == MEAS_HIGH) ? fall : rise;
  assign cap_first  = (state_q == ST_WAIT_FIRST)  && rise       && !start;
  assign cap_second = (state_q == ST_WAIT_SECOND) && second_evt && !start;
  assign done       = (state_q == ST_DONE);

  always_comb begin
    state_nxt = state_q;
    if (start) begin
      state_nxt = ST_WAIT_FIRST;
    end else begin
      case (state_q)
        ST_WAIT_FIRST:  if (cap_first)  state_nxt = ST_WAIT_SECOND;
        ST_WAIT_SECOND: if (cap_second) state_nxt = ST_DONE;
        ST_DONE:        state_nxt = ST_IDLE;
        default:        state_nxt = state_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      mode_q  <= MEAS_PERIOD;
    end else begin
      if (start) mode_q <= meas_mode_t'(mode_in);
      state_q <= state_nxt;
    end
  end

  // R5
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (state_q == ST_WAIT_FIRST) && !done);

  // R6
  idle_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE) |-> !cap_first && !cap_second);

  // R7
  start_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (state_q != ST_WAIT_SECOND));
endmodule

// File: rtl/pwm_diff_reg.sv
module pwm_diff_reg #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] count,
  input  logic             cap_first,
  input  logic             cap_second,
  output logic [CNT_W-1:0] result
);
  logic [CNT_W-1:0] t1_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      t1_q   <= '0;
      result <= '0;
    end else begin
      if (cap_first)  t1_q   <= count;
      if (cap_second) result <= count - t1_q;
    end
  end

  // R5
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_second |=> $stable(result));

  // R2
  single_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cap_first, cap_second}));
endmodule

// File: rtl/pw_period_meter.sv
module pw_period_meter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             mode,
  input  logic             sig_in,
  input  logic [CNT_W-1:0] count,
  output logic             done,
  output logic [CNT_W-1:0] result
);
  logic rise, fall, cap_first, cap_second;

  pwm_edge_detect u_edge (
    .clk(clk), .rst_n(rst_n), .sig_in(sig_in), .rise(rise), .fall(fall)
  );

  pwm_meas_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start), .mode_in(mode),
    .rise(rise), .fall(fall), .cap_first(cap_first),
    .cap_second(cap_second), .done(done)
  );

  pwm_diff_reg #(.CNT_W(CNT_W)) u_diff (
    .clk(clk), .rst_n(rst_n), .count(count), .cap_first(cap_first),
    .cap_second(cap_second), .result(result)
  );
endmodule

// File: tb/pw_period_meter_tb.sv
`timescale 1ns/1ps
module pw_period_meter_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        mode = 1'b0;
  logic        sig_in = 1'b0;
  logic [15:0] count = '0;
  logic        done;
  logic [15:0] result;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  pw_period_meter #(.CNT_W(16)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
    .sig_in(sig_in), .count(count), .done(done), .result(result)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_start(input logic m);
    start = 1'b1; mode = m;
    step();
    start = 1'b0;
  endtask

  // full measurement, sig_in low on entry and on exit
  task automatic measure(input logic m, input logic [15:0] t1, input logic [15:0] t2,
                         input string req);
    do_start(m);
    sig_in = 1'b1; count = t1;
    step();
    chk(req, {15'd0, done}, 16'd0);
    if (m) begin
      sig_in = 1'b0; count = t2;
      step();
    end else begin
      sig_in = 1'b0; count = t1 + 16'd3;
      step();
      chk("R2 fall ignored", {15'd0, done}, 16'd0);
      sig_in = 1'b1; count = t2;
      step();
    end
    chk(req, {15'd0, done}, 16'd1);
    chk(req, result, t2 - t1);
    sig_in = 1'b0;
    step();
    chk("R5 one-cycle done", {15'd0, done}, 16'd0);
    chk("R5 hold", result, t2 - t1);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] held;
    @(negedge clk);
    step(); step();
    chk("R1 done", {15'd0, done}, 16'd0);
    chk("R1 result", result, 16'd0);
    rst_n = 1'b1;
    step();

    // R6: toggling while idle
    for (int i = 0; i < 6; i++) begin
      sig_in = ~sig_in; count = 16'(i * 7);
      step();
      chk("R6 idle done", {15'd0, done}, 16'd0);
      chk("R6 idle result", result, 16'd0);
    end
    sig_in = 1'b0; step();

    // R2 R3 R4 sweep
    for (int m = 0; m < 2; m++) begin
      for (int b = 0; b < 5; b++) begin
        logic [15:0] base;
        case (b)
          0: base = 16'h0000;
          1: base = 16'h0001;
          2: base = 16'h7FFF;
          3: base = 16'hFFF0;
          default: base = 16'hFFFF;
        endcase
        for (int d = 0; d < 70000; d += 3001) begin
          measure(logic'(m), base, base + 16'(d), m ? "R3 pulse R4" : "R2 period R4");
        end
        measure(logic'(m), base, base + 16'hFFFF, "R4 max gap");
      end
    end

    // R7: edge in start cycle, pulse mode
    sig_in = 1'b1; start = 1'b1; mode = 1'b1; count = 16'd40;
    step();
    start = 1'b0; sig_in = 1'b0; count = 16'd45;
    step();
    chk("R7 same-cycle edge", {15'd0, done}, 16'd0);
    // R7: level already high at start
    sig_in = 1'b1; step();
    do_start(1'b1);
    sig_in = 1'b0; count = 16'd90;
    step();
    chk("R7 stale level", {15'd0, done}, 16'd0);
    sig_in = 1'b1; count = 16'd500; step();
    sig_in = 1'b0; count = 16'd530; step();
    chk("R7 done", {15'd0, done}, 16'd1);
    chk("R7 result", result, 16'd30);
    step();

    // R8: restart after first capture, period mode
    do_start(1'b0);
    sig_in = 1'b1; count = 16'd10; step();
    sig_in = 1'b0; step();
    do_start(1'b0);
    chk("R8 no done", {15'd0, done}, 16'd0);
    sig_in = 1'b1; count = 16'd200; step();
    sig_in = 1'b0; step();
    sig_in = 1'b1; count = 16'd260; step();
    chk("R8 done", {15'd0, done}, 16'd1);
    chk("R8 result", result, 16'd60);
    sig_in = 1'b0; step();

    // R9: mode change mid-run ignored
    do_start(1'b1);
    mode = 1'b0;
    sig_in = 1'b1; count = 16'd1000; step();
    sig_in = 1'b0; count = 16'd1017; step();
    chk("R9 done", {15'd0, done}, 16'd1);
    chk("R9 result", result, 16'd17);
    step();

    // R6 after done: idle edges leave result alone
    held = result;
    for (int i = 0; i < 4; i++) begin
      sig_in = ~sig_in; count = 16'(i + 3000);
      step();
      chk("R6 post idle", {15'd0, done}, 16'd0);
      chk("R6 post result", result, held);
    end

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule